// File: doc/BRIEF.md
# Three-Port Serial Memory Device-Address Decoder

This block sits behind three independent two-wire serial slave ports that share one memory. The memory holds two banks of 256 bytes and a 16-byte configuration area. An upstream bit receiver on each port reports START and STOP conditions and hands over each sampled data bit. From these, the block decodes the first byte after every START. That byte carries a 7-bit device address, MSB first, and then a read/write bit. For each port the block reports whether the address was claimed. It raises a one-cycle acknowledge request so that the pin driver holds the line low during the ninth clock. It also reports which storage the transfer targets and the transfer direction.

Each of the two bank ports owns one bank. It answers to the device code 1010b followed by its own 3-bit programmable address. The control port compares only two programmable bits. It uses the last address bit to choose a bank, so the two banks appear to it as one 512-byte space. The control port also reaches the configuration area through a fixed address that cannot be reprogrammed.

The programmable address fields are stored in three configuration bytes. A write to one of those bytes is seen here as a strobe carrying the byte location and the low three data bits. The new field is used from the next START on that port.

Top module: `ee_addr_dec`

## Requirements
- R1: Port 0 claims a byte whose bits [7:4] are 1010b and whose bits [3:1] equal its programmed 3-bit field. It then reports target 2'b01 (bank 1).
- R2: Port 1 claims a byte whose bits [7:4] are 1010b and whose bits [3:1] equal its own programmed 3-bit field. It then reports target 2'b10 (bank 2).
- R3: Port 2 (control) claims a byte whose bits [7:4] are 1010b and whose bits [3:2] equal its programmed 2-bit field. Bit [1] then picks the bank: 0 gives target 2'b01 and 1 gives target 2'b10.
- R4: Port 2 claims the byte whose bits [7:1] are 1011100b whatever its programmed field holds, and reports target 2'b11 (configuration area). Ports 0 and 1 never claim that address.
- R5: Bit [0] of a claimed byte appears on rw_o. 1 means read and 0 means write. It is held while the claim lasts.
- R6: When an address byte is not claimed, the port raises no acknowledge, keeps match low and target 2'b00, and ignores further bits until the next START.
- R7: After reset every output is zero and every programmable field is zero. Port 0 then claims 0xA0/0xA1, port 1 claims 0xA0/0xA1, and port 2 claims 0xA0–0xA3.
- R8: A configuration strobe at location 0, 1 or 2 loads data bits [2:0], [2:0] or [1:0] into the field of port 0, 1 or 2 respectively. Strobes at any other location change nothing. A port keeps the field it latched at its last START, so a change made during an address byte takes effect from the next START.
- R9: A STOP clears match and target in the next cycle and returns the port to idle. A START, including one in the middle of an address byte, restarts decoding from the first bit.
- R10: The acknowledge is a single-cycle pulse in the cycle after the eighth bit is accepted, and it comes together with match. Match, target and direction then hold, whatever bits follow, until START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 3 | Per-port START (or repeated START) strobe |
| stop_i | input | 3 | Per-port STOP strobe |
| bit_vld_i | input | 3 | Per-port strobe: a data bit was sampled |
| bit_i | input | 3 | Per-port sampled data bit |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 4 | Configuration byte location being written |
| cfg_field_i | input | 3 | Low three bits of the written configuration byte |
| match_o | output | 3 | Per-port: address byte claimed |
| ack_o | output | 3 | Per-port one-cycle acknowledge request |
| tgt_o | output | 3x2 | Per-port target: 00 none, 01 bank 1, 10 bank 2, 11 configuration |
| rw_o | output | 3 | Per-port direction from the claimed byte, 1 = read |

## Verification
The checker watches the fixed relations on every cycle. Each acknowledge is one cycle long and comes with match. A new claim only follows an accepted bit. STOP clears the claim. Ports 0 and 1 always report their own bank, and target stays zero without a claim. A held claim keeps its target and direction. The bench scenarios are needed for whether a particular byte is claimed, since that depends on the programmed fields. The same goes for the control port's bank-select bit and fixed configuration address, strobes at unrelated locations, a field change during an address byte taking effect only at the next START, and restarts caused by a START in the middle of a byte.

// File: rtl/ee_dec_pkg.sv
package ee_dec_pkg;
    localparam int NPORT     = 3;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int FIELD_W   = 3;
    localparam int CFG_AW    = 4;

    localparam int KIND_BANK1 = 0;
    localparam int KIND_BANK2 = 1;
    localparam int KIND_CTRL  = 2;

    localparam logic [3:0] DEV_CODE   = 4'b1010;
    localparam logic [6:0] CFG_DEV_AD = 7'b1011100;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'b00,
        TGT_BANK1 = 2'b01,
        TGT_BANK2 = 2'b10,
        TGT_CFG   = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HIT,
        ST_MISS
    } pst_e;
endpackage

// File: rtl/ee_cfg_fields.sv
module ee_cfg_fields
    import ee_dec_pkg::*;
#(
    parameter logic [CFG_AW-1:0] LOC_P0 = 4'd0,
    parameter logic [CFG_AW-1:0] LOC_P1 = 4'd1,
    parameter logic [CFG_AW-1:0] LOC_P2 = 4'd2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [CFG_AW-1:0]   addr_i,
    input  logic [FIELD_W-1:0]  field_i,
    output logic [FIELD_W-1:0]  f0_o,
    output logic [FIELD_W-1:0]  f1_o,
    output logic [FIELD_W-2:0]  f2_o
);
    typedef struct packed {
        logic [FIELD_W-1:0] f0;
        logic [FIELD_W-1:0] f1;
        logic [FIELD_W-2:0] f2;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            if (addr_i == LOC_P0) s_d.f0 = field_i;
            if (addr_i == LOC_P1) s_d.f1 = field_i;
            if (addr_i == LOC_P2) s_d.f2 = field_i[FIELD_W-2:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign f0_o = s_q.f0;
    assign f1_o = s_q.f1;
    assign f2_o = s_q.f2;
endmodule

// File: rtl/ee_port_dec.sv
module ee_port_dec
    import ee_dec_pkg::*;
#(
    parameter int KIND = KIND_BANK1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               bit_vld_i,
    input  logic               bit_i,
    input  logic [FIELD_W-1:0] cmp_i,
    output logic               match_o,
    output logic               ack_o,
    output logic [1:0]         tgt_o,
    output logic               rw_o
);
    typedef struct packed {
        pst_e               st;
        logic [BYTE_W-2:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic [FIELD_W-1:0] cmp;
        logic               ack;
        tgt_e               tgt;
        logic               rw;
    } port_t;

    port_t s_d, s_q;
    logic [BYTE_W-1:0] byte_w;
    logic              dev_ok;
    logic              hit_w;
    tgt_e              tgt_w;

    assign byte_w = {s_q.sh, bit_i};
    assign dev_ok = (byte_w[7:4] == DEV_CODE);

    always_comb begin
        hit_w = 1'b0;
        tgt_w = TGT_NONE;
        case (KIND)
            KIND_BANK1: begin
                hit_w = dev_ok && (byte_w[3:1] == s_q.cmp);
                tgt_w = TGT_BANK1;
            end
            KIND_BANK2: begin
                hit_w = dev_ok && (byte_w[3:1] == s_q.cmp);
                tgt_w = TGT_BANK2;
            end
            default: begin
                if (byte_w[7:1] == CFG_DEV_AD) begin
                    hit_w = 1'b1;
                    tgt_w = TGT_CFG;
                end else begin
                    hit_w = dev_ok && ({1'b0, byte_w[3:2]} == s_q.cmp);
                    tgt_w = byte_w[1] ? TGT_BANK2 : TGT_BANK1;
                end
            end
        endcase
    end

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        if (start_i) begin
            s_d.st  = ST_SHIFT;
            s_d.cnt = '0;
            s_d.sh  = '0;
            s_d.cmp = cmp_i;
            s_d.tgt = TGT_NONE;
            s_d.rw  = 1'b0;
        end else if (stop_i) begin
            s_d.st  = ST_IDLE;
            s_d.tgt = TGT_NONE;
            s_d.rw  = 1'b0;
        end else if (s_q.st == ST_SHIFT && bit_vld_i) begin
            if (s_q.cnt == CNT_W'(BYTE_W - 1)) begin
                if (hit_w) begin
                    s_d.st  = ST_HIT;
                    s_d.ack = 1'b1;
                    s_d.tgt = tgt_w;
                    s_d.rw  = byte_w[0];
                end else begin
                    s_d.st  = ST_MISS;
                end
            end else begin
                s_d.sh  = byte_w[BYTE_W-2:0];
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.tgt <= TGT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign match_o = (s_q.st == ST_HIT);
    assign ack_o   = s_q.ack;
    assign tgt_o   = s_q.tgt;
    assign rw_o    = s_q.rw;
endmodule

// File: rtl/ee_addr_dec.sv
module ee_addr_dec
    import ee_dec_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NPORT-1:0]       start_i,
    input  logic [NPORT-1:0]       stop_i,
    input  logic [NPORT-1:0]       bit_vld_i,
    input  logic [NPORT-1:0]       bit_i,
    input  logic                   cfg_we_i,
    input  logic [CFG_AW-1:0]      cfg_addr_i,
    input  logic [FIELD_W-1:0]     cfg_field_i,
    output logic [NPORT-1:0]       match_o,
    output logic [NPORT-1:0]       ack_o,
    output logic [NPORT-1:0][1:0]  tgt_o,
    output logic [NPORT-1:0]       rw_o
);
    logic [FIELD_W-1:0]            f0_w, f1_w;
    logic [FIELD_W-2:0]            f2_w;
    logic [NPORT-1:0][FIELD_W-1:0] cmp_w;

    ee_cfg_fields u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .field_i (cfg_field_i),
        .f0_o    (f0_w),
        .f1_o    (f1_w),
        .f2_o    (f2_w)
    );

    assign cmp_w[KIND_BANK1] = f0_w;
    assign cmp_w[KIND_BANK2] = f1_w;
    assign cmp_w[KIND_CTRL]  = {1'b0, f2_w};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ee_port_dec #(.KIND(p)) u_dec (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .start_i   (start_i[p]),
            .stop_i    (stop_i[p]),
            .bit_vld_i (bit_vld_i[p]),
            .bit_i     (bit_i[p]),
            .cmp_i     (cmp_w[p]),
            .match_o   (match_o[p]),
            .ack_o     (ack_o[p]),
            .tgt_o     (tgt_o[p]),
            .rw_o      (rw_o[p])
        );
    end
endmodule

// File: rtl/ee_addr_dec_chk.sv
module ee_addr_dec_chk
    import ee_dec_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [NPORT-1:0]      start_i,
    input logic [NPORT-1:0]      stop_i,
    input logic [NPORT-1:0]      bit_vld_i,
    input logic [NPORT-1:0]      match_o,
    input logic [NPORT-1:0]      ack_o,
    input logic [NPORT-1:0][1:0] tgt_o,
    input logic [NPORT-1:0]      rw_o
);
    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        p_ack_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ack_o[i] |=> !ack_o[i]);
        p_ack_with_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ack_o[i] |-> match_o[i]);
        p_claim_after_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(match_o[i]) |-> ($past(bit_vld_i[i]) && ack_o[i]));
        p_stop_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (stop_i[i] && !start_i[i]) |=> (!match_o[i] && tgt_o[i] == 2'b00));
        p_no_tgt_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !match_o[i] |-> (tgt_o[i] == 2'b00));
        p_claim_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (match_o[i] && !start_i[i] && !stop_i[i]) |=>
            (match_o[i] && $stable(rw_o[i]) && $stable(tgt_o[i])));
    end

    p_port0_bank1_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o[KIND_BANK1] |-> (tgt_o[KIND_BANK1] == 2'b01));
    p_port1_bank2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o[KIND_BANK2] |-> (tgt_o[KIND_BANK2] == 2'b10));
    p_ctrl_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o[KIND_CTRL] |-> (tgt_o[KIND_CTRL] != 2'b00));
endmodule

bind ee_addr_dec ee_addr_dec_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .bit_vld_i (bit_vld_i),
    .match_o   (match_o),
    .ack_o     (ack_o),
    .tgt_o     (tgt_o),
    .rw_o      (rw_o)
);

// File: tb/ee_addr_dec_tb.sv
module ee_addr_dec_tb;
    import ee_dec_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic                   clk_i = 1'b0;
    logic                   rst_ni = 1'b0;
    logic [NPORT-1:0]       start_i = '0, stop_i = '0, bit_vld_i = '0, bit_i = '0;
    logic                   cfg_we_i = 1'b0;
    logic [CFG_AW-1:0]      cfg_addr_i = '0;
    logic [FIELD_W-1:0]     cfg_field_i = '0;
    logic [NPORT-1:0]       match_o, ack_o, rw_o;
    logic [NPORT-1:0][1:0]  tgt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    ee_addr_dec u_dut (.*);

    typedef struct packed {
        logic [1:0] port;
        logic [7:0] dat;
        logic       hit;
        logic [1:0] tgt;
        logic       rw;
    } vec_t;

    // Fields programmed before the table: port0=101, port1=010, port2=11
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'hAA, 1'b1, 2'b01, 1'b0},
        '{2'd0, 8'hAB, 1'b1, 2'b01, 1'b1},
        '{2'd0, 8'hA0, 1'b0, 2'b00, 1'b0},
        '{2'd0, 8'h2A, 1'b0, 2'b00, 1'b0},
        '{2'd0, 8'hB8, 1'b0, 2'b00, 1'b0},
        '{2'd1, 8'hA4, 1'b1, 2'b10, 1'b0},
        '{2'd1, 8'hA5, 1'b1, 2'b10, 1'b1},
        '{2'd1, 8'hAA, 1'b0, 2'b00, 1'b0},
        '{2'd1, 8'hB9, 1'b0, 2'b00, 1'b0},
        '{2'd2, 8'hAC, 1'b1, 2'b01, 1'b0},
        '{2'd2, 8'hAF, 1'b1, 2'b10, 1'b1},
        '{2'd2, 8'hA0, 1'b0, 2'b00, 1'b0},
        '{2'd2, 8'hB8, 1'b1, 2'b11, 1'b0},
        '{2'd2, 8'hB9, 1'b1, 2'b11, 1'b1},
        '{2'd2, 8'hBA, 1'b0, 2'b00, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_in();
        start_i = '0; stop_i = '0; bit_vld_i = '0; bit_i = '0;
        cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_field_i = '0;
    endtask

    task automatic t_idle();
        @(negedge clk_i); clr_in();
    endtask
    task automatic t_start(input int p);
        @(negedge clk_i); clr_in(); start_i[p] = 1'b1;
    endtask
    task automatic t_stop(input int p);
        @(negedge clk_i); clr_in(); stop_i[p] = 1'b1;
    endtask
    task automatic t_bit(input int p, input logic v);
        @(negedge clk_i); clr_in(); bit_vld_i[p] = 1'b1; bit_i[p] = v;
    endtask
    task automatic t_cfg(input int a, input int f);
        @(negedge clk_i); clr_in(); cfg_we_i = 1'b1;
        cfg_addr_i = CFG_AW'(a); cfg_field_i = FIELD_W'(f);
    endtask
    task automatic bits(input int p, input logic [7:0] b, input int hi, input int lo);
        for (int k = hi; k >= lo; k--) t_bit(p, b[k]);
    endtask
    // START, eight bits, then one idle negedge: sample point for ack/match
    task automatic send(input int p, input logic [7:0] b);
        t_start(p); bits(p, b, 7, 0); t_idle();
    endtask
    task automatic expect_res(input string req, input int p, input logic hit,
                              input logic [1:0] tg, input logic rw);
        chk({req, " match"}, match_o[p], hit);
        chk({req, " ack"},   ack_o[p],   hit);
        chk({req, " tgt"},   tgt_o[p],   tg);
        chk({req, " rw"},    rw_o[p],    hit ? rw : 1'b0);
        t_idle();
        chk({req, " ack pulse R10"}, ack_o[p], 0);
        chk({req, " match hold"}, match_o[p], hit);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R7: reset state
        chk("R7 match", match_o, 0);
        chk("R7 ack", ack_o, 0);
        chk("R7 tgt", tgt_o, 0);
        chk("R7 rw", rw_o, 0);
        rst_ni = 1'b1;
        t_idle();

        // R7: fields are zero after reset
        send(0, 8'hA1); expect_res("R7 p0", 0, 1'b1, 2'b01, 1'b1);
        send(1, 8'hA0); expect_res("R7 p1", 1, 1'b1, 2'b10, 1'b0);
        send(2, 8'hA2); expect_res("R7 p2", 2, 1'b1, 2'b10, 1'b0);
        send(2, 8'hA3); expect_res("R7 p2b", 2, 1'b1, 2'b10, 1'b1);
        send(0, 8'hAA); expect_res("R7 p0 miss", 0, 1'b0, 2'b00, 1'b0);

        // R8: program fields, plus strobes at unrelated locations
        t_cfg(0, 5); t_cfg(1, 2); t_cfg(2, 3);
        t_cfg(5, 7); t_cfg(15, 0); t_cfg(3, 0);
        t_idle();

        for (int v = 0; v < NV; v++) begin
            string r;
            if (!VEC[v].hit)              r = "R6";
            else if (VEC[v].tgt == 2'b11) r = "R4";
            else if (VEC[v].port == 2'd0) r = "R1";
            else if (VEC[v].port == 2'd1) r = "R2";
            else                          r = "R3";
            send(int'(VEC[v].port), VEC[v].dat);
            expect_res(r, int'(VEC[v].port), VEC[v].hit, VEC[v].tgt, VEC[v].rw);
        end

        // R6: after a miss, bits without START are ignored
        send(0, 8'hA0);
        bits(0, 8'hAA, 7, 0); t_idle();
        chk("R6 ignore after miss", match_o[0], 0);
        chk("R6 no ack after miss", ack_o[0], 0);

        // R10: after a claim, further bits leave it unchanged
        send(1, 8'hA5); t_idle();
        bits(1, 8'h00, 7, 0); t_idle();
        chk("R10 hold match", match_o[1], 1);
        chk("R10 hold tgt", tgt_o[1], 2);
        chk("R10 hold rw", rw_o[1], 1);
        chk("R10 no reack", ack_o[1], 0);

        // R9: STOP clears claim
        t_stop(1); t_idle();
        chk("R9 stop match", match_o[1], 0);
        chk("R9 stop tgt", tgt_o[1], 0);

        // R9: repeated START mid-byte restarts decoding
        t_start(2); bits(2, 8'h00, 7, 4);
        send(2, 8'hB9);
        chk("R9 restart match", match_o[2], 1);
        chk("R9 restart tgt", tgt_o[2], 3);
        t_idle();

        // R9: STOP mid-byte aborts; remaining bits ignored
        t_start(0); bits(0, 8'hAA, 7, 4); t_stop(0);
        bits(0, 8'hAA, 3, 0); bits(0, 8'hAA, 7, 4); t_idle();
        chk("R9 abort match", match_o[0], 0);
        chk("R9 abort ack", ack_o[0], 0);

        // R8: field change during an address byte applies from next START
        t_start(0); bits(0, 8'hAA, 7, 5);
        t_cfg(0, 1);
        bits(0, 8'hAA, 4, 0); t_idle();
        chk("R8 old field used", match_o[0], 1);
        send(0, 8'hAA); expect_res("R8 old field dropped", 0, 1'b0, 2'b00, 1'b0);
        send(0, 8'hA2); expect_res("R8 new field", 0, 1'b1, 2'b01, 1'b0);

        // R4: configuration address stays fixed after control field change
        t_cfg(2, 0);
        send(2, 8'hB8); expect_res("R4 fixed", 2, 1'b1, 2'b11, 1'b0);
        send(2, 8'hA1); expect_res("R3 new field", 2, 1'b1, 2'b01, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule